// File: doc/BRIEF.md
# UART Register Bank Selector

This block keeps the bank-selection state of a UART register file that places several banks of registers behind a narrow address window. A single byte at offset 03h does two jobs. Written with its top bit clear, it is an ordinary line-control value and also returns the window to bank 0. Written with its top bit set, it is a bank-select command, and the line-control value is left as it was. Downstream register decode reads the resulting bank number and a reserved flag, and uses them to steer every other offset.

The bank is encoded in a sparse pattern. Any value of the form 10xxxxxx selects bank 1. Six exact byte values select banks 2 to 7. Every other value with the top bit set is a reserved code. For a reserved code the block raises its reserved flag and still presents bank 0, so that decode never reaches an undefined bank. A read of the shared byte returns the last value written to that offset, whichever of the two functions it served. Software can therefore save and restore the window state with a plain read and write.

Top module: `uart_bank_sel`

## Requirements
- R1: After reset, selByte reads 00h, lineCtrl reads 00h, bankNum is 0 and bankReserved is 0.
- R2: A write to any offset other than 03h leaves selByte, lineCtrl, bankNum and bankReserved unchanged.
- R3: A write to offset 03h with bit 7 = 0 loads lineCtrl with the byte, sets bankNum to 0 and clears bankReserved, whatever bits 6-0 hold.
- R4: A write to offset 03h with bit 7 = 1 leaves lineCtrl unchanged.
- R5: A write to offset 03h of any byte whose bits 7:6 are 2'b10 sets bankNum to 1 and clears bankReserved.
- R6: A write to offset 03h of E0h, E4h, E8h, ECh, F0h or F4h sets bankNum to 2, 3, 4, 5, 6 or 7 respectively and clears bankReserved.
- R7: A write to offset 03h of any other byte with bit 7 = 1 (patterns 110xxxxx, 111xxxxx with bits 1:0 nonzero, F8h, FCh) sets bankReserved to 1 and bankNum to 0.
- R8: selByte always holds the last byte written to offset 03h, whether it was a line-control or a bank-select write.
- R9: A write becomes visible on all outputs right after the clock edge at which wrEn is sampled high. A write in the next cycle is decoded against the new state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | ADDR_W (3) | Register offset of the write |
| wrData | input | 8 | Write data byte |
| selByte | output | 8 | Readback of the shared byte at offset 03h |
| lineCtrl | output | 8 | Current line-control value |
| bankNum | output | BANK_W (3) | Bank presented to register decode |
| bankReserved | output | 1 | Last shared-byte write was a reserved code |

## Verification
The bench builds the block with its defaults: a 3-bit offset, the shared byte at offset 03h and eight banks. With these values all six exact bank codes, the whole 10xxxxxx range and every reserved shape can be reached with byte stimulus. Writes at offsets other than 03h can be mixed in so that they land between the decoded writes. Back-to-back writes on consecutive cycles test that each write is decoded from the state left by the one before it.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic selWr;   // any write to the shared byte
    logic lineWr;  // write that also loads line control
  } strobe_t;

  // exact byte code for banks 2 and above: E0h plus four per step
  function automatic logic [DATA_W-1:0] bankCode(input int k);
    return 8'hE0 + 8'(4 * (k - 2));
  endfunction
endpackage

// File: rtl/ubs_ctrl.sv
module ubs_ctrl
  import ubs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int SEL_OFFSET = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobes
);
  localparam logic [ADDR_W-1:0] SelAddr = ADDR_W'(SEL_OFFSET);

  logic hitSel;

  always_comb begin
    hitSel         = wrEn && (wrAddr == SelAddr);
    strobes.selWr  = hitSel;
    strobes.lineWr = hitSel && !wrData[DATA_W-1];
  end
endmodule

// File: rtl/ubs_datapath.sv
module ubs_datapath
  import ubs_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] selByte,
  output logic [DATA_W-1:0] lineCtrl,
  output logic [BANK_W-1:0] bankNum,
  output logic              bankReserved
);
  logic [NUM_BANKS-1:0] hit;
  logic [BANK_W-1:0]    nextBank;
  logic                 nextRes;

  assign hit[0] = !wrData[DATA_W-1];
  assign hit[1] = (wrData[DATA_W-1 -: 2] == 2'b10);

  for (genvar k = 2; k < NUM_BANKS; k++) begin : g_code
    assign hit[k] = (wrData == bankCode(k));
  end

  always_comb begin
    nextBank = '0;
    nextRes  = !(|hit);
    for (int k = 1; k < NUM_BANKS; k++) begin
      if (hit[k]) nextBank = BANK_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selByte      <= '0;
      lineCtrl     <= '0;
      bankNum      <= '0;
      bankReserved <= 1'b0;
    end else begin
      if (strobes.selWr) begin
        selByte      <= wrData;
        bankNum      <= nextBank;
        bankReserved <= nextRes;
      end
      if (strobes.lineWr) lineCtrl <= wrData;
    end
  end
endmodule

// File: rtl/uart_bank_sel.sv
module uart_bank_sel
  import ubs_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int SEL_OFFSET = 3,
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        selByte,
  output logic [7:0]        lineCtrl,
  output logic [BANK_W-1:0] bankNum,
  output logic              bankReserved
);
  strobe_t strobes;

  ubs_ctrl #(.ADDR_W(ADDR_W), .SEL_OFFSET(SEL_OFFSET)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobes(strobes)
  );

  ubs_datapath #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .selByte     (selByte),
    .lineCtrl    (lineCtrl),
    .bankNum     (bankNum),
    .bankReserved(bankReserved)
  );
endmodule

// File: rtl/uart_bank_sel_chk.sv
module uart_bank_sel_chk #(
  parameter int ADDR_W = 3,
  parameter int SEL_OFFSET = 3,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [7:0]        selByte,
  input logic [7:0]        lineCtrl,
  input logic [BANK_W-1:0] bankNum,
  input logic              bankReserved
);
  logic selWrite;
  assign selWrite = wrEn && (wrAddr == ADDR_W'(SEL_OFFSET));

  // R2: other offsets and idle cycles change nothing
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !selWrite |=> ($stable(selByte) && $stable(lineCtrl) && $stable(bankNum) && $stable(bankReserved)));

  // R3: top bit clear returns to bank 0 and loads line control
  assert_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && !wrData[7]) |=> (bankNum == '0 && !bankReserved && lineCtrl == $past(wrData)));

  // R4: bank-select writes keep line control
  assert_keep_line_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && wrData[7]) |=> $stable(lineCtrl));

  // R5: 10xxxxxx gives bank 1
  assert_bank1_R5: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && wrData[7:6] == 2'b10) |=> (bankNum == BANK_W'(1) && !bankReserved));

  // R6: E0h reaches bank 2
  assert_bank2_R6: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && wrData == 8'hE0) |=> (bankNum == BANK_W'(2) && !bankReserved));

  // R7: reserved code always presents bank 0
  assert_res_bank0_R7: assert property (@(posedge clk) disable iff (!rstN)
    bankReserved |-> (bankNum == '0));

  // R8, R9: readback holds the byte from the previous cycle's write
  assert_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    selWrite |=> (selByte == $past(wrData)));
endmodule

bind uart_bank_sel uart_bank_sel_chk #(
  .ADDR_W(ADDR_W), .SEL_OFFSET(SEL_OFFSET), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .selByte(selByte), .lineCtrl(lineCtrl), .bankNum(bankNum), .bankReserved(bankReserved)
);

// File: tb/uart_bank_sel_tb.sv
module uart_bank_sel_tb;
  localparam int ClkPeriod = 10;
  localparam int ADDR_W = 3;
  localparam int BANK_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] selByte, lineCtrl;
  logic [BANK_W-1:0] bankNum;
  logic bankReserved;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] expSel = 8'h00, expLine = 8'h00;
  logic [2:0] expBank = 3'd0;
  logic expRes = 1'b0;

  always #(ClkPeriod / 2) clk = ~clk;

  uart_bank_sel u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .selByte(selByte), .lineCtrl(lineCtrl), .bankNum(bankNum), .bankReserved(bankReserved)
  );

  // model of the encoding, returns {reserved, bank}
  function automatic logic [3:0] decodeByte(input logic [7:0] b);
    if (!b[7]) return 4'b0_000;
    if (b[7:6] == 2'b10) return 4'b0_001;
    case (b)
      8'hE0: return 4'b0_010;
      8'hE4: return 4'b0_011;
      8'hE8: return 4'b0_100;
      8'hEC: return 4'b0_101;
      8'hF0: return 4'b0_110;
      8'hF4: return 4'b0_111;
      default: return 4'b1_000;
    endcase
  endfunction

  function automatic void modelWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    logic [3:0] r;
    if (a != 3'd3) return;
    r = decodeByte(d);
    expSel = d;
    if (!d[7]) expLine = d;
    expBank = r[2:0];
    expRes = r[3];
  endfunction

  task automatic checkAll(input string req);
    total++;
    if (selByte !== expSel || lineCtrl !== expLine || bankNum !== expBank || bankReserved !== expRes) begin
      bad++;
      $display("FAIL %s: got sel=%h line=%h bank=%0d res=%b, expected sel=%h line=%h bank=%0d res=%b",
               req, selByte, lineCtrl, bankNum, bankReserved, expSel, expLine, expBank, expRes);
    end
  endtask

  // drive at negedge, outputs settle after the next posedge, checked at the following negedge
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    modelWrite(a, d);
    @(negedge clk);
    wrEn = 1'b0;
    checkAll(req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release");

    // R6 each exact code, R4 line control held
    doWrite(3'd3, 8'h35, "R3 line write");
    doWrite(3'd3, 8'hE0, "R6 bank2");
    doWrite(3'd3, 8'hE4, "R6 bank3");
    doWrite(3'd3, 8'hE8, "R6 bank4");
    doWrite(3'd3, 8'hEC, "R6 bank5");
    doWrite(3'd3, 8'hF0, "R6 bank6");
    doWrite(3'd3, 8'hF4, "R4 R6 bank7");
    // R5 range ends
    doWrite(3'd3, 8'h80, "R5 bank1 low");
    doWrite(3'd3, 8'hBF, "R5 bank1 high");
    // R3 top bit clear, bits 6-0 ignored for bank
    doWrite(3'd3, 8'h7F, "R3 bank0 7F");
    // R7 reserved shapes, R8 readback of them
    doWrite(3'd3, 8'hC0, "R7 reserved C0");
    doWrite(3'd3, 8'hE1, "R7 reserved E1");
    doWrite(3'd3, 8'hE6, "R7 reserved E6");
    doWrite(3'd3, 8'hF8, "R7 reserved F8");
    doWrite(3'd3, 8'hFC, "R7 R8 reserved FC");
    doWrite(3'd3, 8'hFF, "R7 reserved FF");
    // R2 other offsets ignored
    doWrite(3'd3, 8'hEC, "R6 setup");
    doWrite(3'd0, 8'h12, "R2 offset0");
    doWrite(3'd7, 8'h80, "R2 offset7");
    doWrite(3'd2, 8'h00, "R2 offset2");

    // R9 back-to-back writes, checked after each edge
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 8'hF0;
    @(posedge clk); modelWrite(3'd3, 8'hF0);
    @(negedge clk); checkAll("R9 first of pair");
    wrData = 8'h55;
    @(posedge clk); modelWrite(3'd3, 8'h55);
    @(negedge clk); checkAll("R9 second of pair");
    wrEn = 1'b0;

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic [7:0] d;
      int pick;
      a = ($urandom_range(0, 3) != 0) ? 3'd3 : ADDR_W'($urandom_range(0, 7));
      pick = $urandom_range(0, 3);
      case (pick)
        0: d = 8'hE0 + 8'($urandom_range(0, 7) * 4);
        1: d = 8'hC0 | 8'($urandom_range(0, 63));
        default: d = 8'($urandom_range(0, 255));
      endcase
      doWrite(a, d, "R2 R3 R5 R6 R7 R8 random");
    end

    // reset mid-run returns to R1 state
    doWrite(3'd3, 8'hF4, "R6 pre-reset");
    rstN = 1'b0;
    @(posedge clk);
    expSel = 8'h00; expLine = 8'h00; expBank = 3'd0; expRes = 1'b0;
    @(negedge clk);
    checkAll("R1 reapplied");
    rstN = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule